// File: doc/BRIEF.md
# Successive-Approximation Time-Difference Resolver

This block is a synthesizable behavioural model of a binary-search time digitizer. It takes a signed time difference between two edges, start time minus stop time, given in fixed-point units of the unit delay τ with one fractional bit. A positive value means the stop edge arrives first. The block resolves this difference into an N-bit code, one bit per clock cycle, starting with the most significant bit.

At every stage a comparator-style arbiter decides which edge leads. The stage's output bit is the inverse of that decision: a stop lead gives 0 and a start lead gives 1. A delay of binary weight is then placed on the leading edge so that the remaining difference shrinks. For stage k (N-1 down to 1) the weight is 2^(k-1) τ, and stage 0 only decides.

A controller starts a conversion when it sees a one-cycle strobe. The code is published together with a one-cycle done pulse and stays unchanged until the next conversion finishes.

Top module: `tdsar_top`

## Requirements
- R1: While reset is active and after it is released, `done_o` is 0 and `code_o` is all zeros until the first conversion finishes.
- R2: Each stage's bit is the inverse of its arbiter decision. A residue greater than zero is a stop lead and gives bit 0, so the MSB of the code is 0 exactly when the sampled difference is positive.
- R3: A residue of exactly zero counts as a start lead and gives bit 1. A zero difference therefore yields 1 followed by N-1 zeros.
- R4: After stage k (k ≥ 1) decides, 2^(k-1) τ (2^k half-units) is subtracted from the residue on a stop lead and added on a start lead. The code bits, from bit N-1 down to bit 0, are the stage decisions in that order.
- R5: `done_o` is high for exactly one cycle, starting N rising edges after the edge that samples an accepted `start_i`.
- R6: `code_o` changes only at the edge where `done_o` rises, and it keeps its value between conversions.
- R7: A `start_i` strobe that arrives while a conversion is running is ignored. The running conversion keeps its timing and its result.
- R8: `diff_i` is sampled only at the edge that accepts `start_i`. Changing it during a conversion has no effect on the result.
- R9: Full-scale inputs saturate cleanly. A difference of +7.5 τ or more (for N=4) gives all zeros, and −8 τ or less gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle strobe that starts a conversion |
| diff_i | input | N+2 | Signed start-minus-stop difference in half-τ units |
| code_o | output | N | Resolved code, MSB first |
| done_o | output | 1 | One-cycle pulse when a new code is published |

## Verification
The residue register is the only state that carries information from one stage to the next. A wrong sign decision or a wrong weight therefore shows up as a wrong lower bit in the code published N cycles later. A sweep across every half-τ input from −8 τ to +7.5 τ exposes any such error on the first conversion that uses the faulty stage. A stuck or skipped step counter shows up directly at the ports as a `done_o` pulse that comes early, late, or lasts longer than one cycle. A start strobe that leaks into a running conversion shows up as a second done pulse or as a code that belongs to the wrong input.

// File: rtl/tdsar_pkg.sv
package tdsar_pkg;
  // Arbiter verdict for one stage
  typedef enum logic {
    LEAD_START = 1'b0,
    LEAD_STOP  = 1'b1
  } lead_e;
endpackage

// File: rtl/tdsar_rst_sync.sv
module tdsar_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tdsar_arbiter.sv
module tdsar_arbiter
  import tdsar_pkg::*;
#(
  parameter int RW = 7
) (
  input  logic signed [RW-1:0] residue_i,
  output lead_e                lead_o
);
  // Positive residue: stop edge is earlier. Zero breaks toward start.
  always_comb begin
    if (residue_i > 0) lead_o = LEAD_STOP;
    else               lead_o = LEAD_START;
  end
endmodule

// File: rtl/tdsar_delay_step.sv
module tdsar_delay_step
  import tdsar_pkg::*;
#(
  parameter int RW = 7,
  parameter int SW = 2
) (
  input  logic signed [RW-1:0] residue_i,
  input  lead_e                lead_i,
  input  logic [SW-1:0]        step_i,
  output logic signed [RW-1:0] residue_o
);
  logic [RW-1:0] weight;

  // Stage k inserts 2^k half-units on the leading edge
  always_comb begin
    weight = {{(RW-1){1'b0}}, 1'b1} << step_i;
    if (lead_i == LEAD_STOP) residue_o = residue_i - $signed(weight);
    else                     residue_o = residue_i + $signed(weight);
  end
endmodule

// File: rtl/tdsar_seq.sv
module tdsar_seq #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_i,
  output logic          load_o,
  output logic          adv_o,
  output logic [SW-1:0] step_o,
  output logic [N-1:0]  code_o,
  output logic          done_o
);
  localparam logic [SW-1:0] LastStep = SW'(N - 1);

  logic          busy_q, busy_d;
  logic [SW-1:0] step_q, step_d;
  logic [N-1:0]  work_q, work_d;
  logic [N-1:0]  code_q, code_d;
  logic          done_q, done_d;
  logic          load;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    work_d = work_q;
    code_d = code_q;
    done_d = 1'b0;
    load   = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        step_d = LastStep;
        work_d = '0;
        load   = 1'b1;
      end
    end else begin
      work_d[step_q] = bit_i;
      if (step_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        code_d = work_d;
      end else begin
        step_d = step_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      work_q <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load || busy_q) begin
        step_q <= step_d;
        work_q <= work_d;
      end
      if (done_d) code_q <= code_d;
    end
  end

  assign load_o = load;
  assign adv_o  = busy_q;
  assign step_o = step_q;
  assign code_o = code_q;
  assign done_o = done_q;
endmodule

// File: rtl/tdsar_top.sv
module tdsar_top
  import tdsar_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic signed [N+1:0] diff_i,
  output logic [N-1:0]      code_o,
  output logic              done_o
);
  localparam int DW = N + 2;
  localparam int RW = DW + 1;
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic                 rst_sync_n;
  logic                 load, adv;
  logic [SW-1:0]        step;
  logic signed [RW-1:0] res_q, res_d, res_step;
  lead_e                lead;
  logic                 stage_bit;

  tdsar_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tdsar_arbiter #(.RW(RW)) u_arb (
    .residue_i (res_q),
    .lead_o    (lead)
  );

  // Output bit is the inverted verdict
  assign stage_bit = (lead == LEAD_START);

  tdsar_delay_step #(.RW(RW), .SW(SW)) u_step (
    .residue_i (res_q),
    .lead_i    (lead),
    .step_i    (step),
    .residue_o (res_step)
  );

  tdsar_seq #(.N(N), .SW(SW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .start_i (start_i),
    .bit_i   (stage_bit),
    .load_o  (load),
    .adv_o   (adv),
    .step_o  (step),
    .code_o  (code_o),
    .done_o  (done_o)
  );

  always_comb begin
    res_d = res_q;
    if (load)     res_d = RW'(diff_i);
    else if (adv) res_d = res_step;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)     res_q <= '0;
    else if (load || adv) res_q <= res_d;
  end
endmodule

// File: rtl/tdsar_checker.sv
module tdsar_checker #(
  parameter int N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic signed [N+1:0] diff_i,
  input logic [N-1:0]      code_o,
  input logic              done_o
);
  localparam int CW = $clog2(N + 1) + 1;

  logic              run_q;
  logic [CW-1:0]     cnt_q;
  logic signed [N+1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= CW'(N);
      lat_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(N - 1)) run_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      lat_q <= diff_i;
    end
  end

  // R5: done exactly N edges after acceptance, one cycle wide
  a_r5_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == CW'(N)) && !run_q);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: code held except at publication
  a_r6_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(code_o));
  // R2: MSB is the inverse of the first verdict
  a_r2_msb_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (code_o[N-1] == (lat_q <= 0)));
  // R3: zero input resolves as a start lead
  a_r3_tie_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && lat_q == 0) |-> (code_o == (N'(1) << (N - 1))));
endmodule

bind tdsar_top tdsar_checker #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .start_i (start_i),
  .diff_i  (diff_i),
  .code_o  (code_o),
  .done_o  (done_o)
);

// File: tb/test_tdsar_top.sv
module test_tdsar_top;
  localparam int N  = 4;
  localparam int DW = N + 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start;
  logic signed [DW-1:0] diff;
  logic [N-1:0]        code;
  logic                done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tdsar_top #(.N(N)) i_tdsar_top (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .diff_i  (diff),
    .code_o  (code),
    .done_o  (done)
  );

  // Reference: binary search on the residue in half-tau units
  function automatic logic [N-1:0] expect_code(int d);
    int r = d;
    logic [N-1:0] c = '0;
    for (int k = N - 1; k >= 0; k--) begin
      c[k] = !(r > 0);
      if (k > 0) r = (r > 0) ? r - (1 << k) : r + (1 << k);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch one conversion; returns latency and code seen with done
  task automatic convert(input int d, output int lat, output logic [N-1:0] got);
    @(negedge clk);
    diff  = DW'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    got = code;
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(code == '0,   "R1 code", int'(code), 0);
  endtask

  task automatic t_single(input int d, input string req);
    int lat;
    logic [N-1:0] got;
    convert(d, lat, got);
    check(lat == N, "R5 latency", lat, N);
    check(got == expect_code(d), req, int'(got), int'(expect_code(d)));
    @(negedge clk);
    check(done == 1'b0, "R5 pulse width", int'(done), 0);
  endtask

  task automatic t_sweep;
    for (int d = -16; d <= 15; d++) t_single(d, "R4 sweep");
  endtask

  task automatic t_hold;
    logic [N-1:0] keep;
    t_single(3, "R2 stop lead 1.5");
    keep = code;
    repeat (6) @(negedge clk);
    check(code == keep, "R6 hold", int'(code), int'(keep));
  endtask

  task automatic t_busy_ignore;
    int lat;
    logic [N-1:0] got;
    int dones = 0;
    @(negedge clk);
    diff  = DW'(5);
    start = 1'b1;
    @(negedge clk);
    diff  = DW'(-9);
    lat = 0;
    // keep strobing and changing the input while running
    while (!done && lat < 40) begin
      @(negedge clk);
      diff = DW'(-3 - lat);
      lat++;
    end
    start = 1'b0;
    got = code;
    check(lat == N, "R7 latency", lat, N);
    check(got == expect_code(5), "R8 sampled input", int'(got), int'(expect_code(5)));
    repeat (2 * N) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R7 extra done", dones, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    diff  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single(0,   "R3 tie zero");
    check(code == 4'b1000, "R3 tie code", int'(code), 8);
    t_single(3,   "R4 stop lead 1.5");
    check(code == 4'b0110, "R4 code 1.5", int'(code), 6);
    t_single(1,   "R2 stop lead 0.5");
    t_single(-1,  "R2 start lead 0.5");
    t_single(15,  "R9 positive full scale");
    check(code == 4'b0000, "R9 zeros", int'(code), 0);
    t_single(-16, "R9 negative full scale");
    check(code == 4'b1111, "R9 ones", int'(code), 15);
    t_hold();
    t_busy_ignore();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule